// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block computes the shifter operand of a RISC-style integer data path. Each cycle it takes a data word, a three-bit shift-kind code, a shift amount and the current carry flag. It returns the shifted word together with the carry the shifter produces. Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The surrounding data path decides whether the amount comes from an immediate field or from a register. It also reads the register file and writes the flags back. This block only shifts.

The shift is computed by a single combinational rotate-and-mask network. The result and carry-out are captured in an output register, so they appear one clock after the inputs are presented. Only the low byte of the amount input takes part. The corner cases are defined exactly for each kind: an amount of zero, an amount equal to the word width, and an amount above the word width.

Top module: `shft_barrel_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_result` and `out_carry` become zero.
- R2: Only bits [7:0] of `in_amount` select the amount. Bits above bit 7 have no effect on either output.
- R3: For kinds 0 (logical left), 1 (logical right), 2 (arithmetic right) and 3 (rotate right), an amount of zero returns the data unchanged, and the carry-out equals `in_carry`.
- R4: For kind 0 (logical left) with amount n from 1 to 32, the result is the data shifted left with zeros filled in. The carry-out is data bit 32−n, so an amount of 32 gives a zero result and carry data bit 0.
- R5: For kind 1 (logical right) with amount n from 1 to 32, the result is the data shifted right with zeros filled in. The carry-out is data bit n−1, so an amount of 32 gives a zero result and carry data bit 31.
- R6: For kind 2 (arithmetic right) with amount n from 1 to 31, the vacated bits copy data bit 31 and the carry-out is data bit n−1. With an amount of 32 or more, every result bit and the carry-out equal data bit 31.
- R7: For kinds 0 and 1 with an amount above 32, the result and the carry-out are both zero.
- R8: For kind 3 (rotate right) with a non-zero amount, the data is rotated right by the amount modulo 32, and the carry-out equals result bit 31. A non-zero multiple of 32 therefore returns the data unchanged, with carry data bit 31.
- R9: For kind 4, the amount is ignored. The result is the data shifted right by one with `in_carry` placed in bit 31, and the carry-out is data bit 0.
- R10: Kind codes 5, 6 and 7 return the data unchanged, with the carry-out equal to `in_carry`.
- R11: Outside reset, the outputs after a rising edge reflect the inputs sampled at that edge, which is a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Data word to shift |
| in_kind | input | 3 | Shift kind code (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry) |
| in_amount | input | 32 | Shift amount; only bits [7:0] are used |
| in_carry | input | 1 | Current carry flag |
| out_result | output | 32 | Shifted word, registered |
| out_carry | output | 1 | Shifter carry-out, registered |

## Verification
The bench tests every kind at the amounts 0, 1, 31, 32, 33 and 255, using random data and both carry values. A design that treated zero as a full-width shift would lose the operand at amount 0. A design that reused the in-range carry rule at 32 would pick the wrong carry bit. A design that wrapped the amount modulo 32 would return a non-zero result at 33 or 255. The bench also checks that arithmetic right shifts of 32 and above fill with the sign, that rotations by non-zero multiples of 32 keep the operand, and that the through-carry rotate ignores the amount. A design that decoded high amount bits would change its output when only bits above bit 7 differ. A design that decoded the spare kind codes would corrupt pass-through words.

// File: rtl/shft_pkg.sv
package shft_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shft_kind_e;

    // Range of the effective amount relative to the word width
    typedef struct packed {
        logic zero;    // amount == 0
        logic below;   // 1 .. W-1
        logic exact;   // amount == W
        logic beyond;  // amount > W
    } amt_class_t;

    // Logical left shifts are built from a right rotation by the negated amount
    function automatic logic rotates_left(input shft_kind_e k);
        return (k == SK_LSL);
    endfunction

    // Kinds whose zero amount passes the operand and carry through unchanged
    function automatic logic zero_passes(input shft_kind_e k);
        return (k == SK_LSL) || (k == SK_LSR) || (k == SK_ASR) || (k == SK_ROR);
    endfunction

endpackage

// File: rtl/shft_amt_decode.sv
module shft_amt_decode
    import shft_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  logic [AMT_W-1:0] amt,
    output amt_class_t       cls,
    output logic [SH_W-1:0]  low
);

    localparam logic [AMT_W-1:0] WIDTH_CODE = AMT_W'(W);

    always_comb begin
        cls.zero   = (amt == '0);
        cls.exact  = (amt == WIDTH_CODE);
        cls.beyond = (amt >  WIDTH_CODE);
        cls.below  = !cls.zero && (amt < WIDTH_CODE);
        low        = amt[SH_W-1:0];
    end

endmodule

// File: rtl/shft_rot_right.sv
module shft_rot_right #(
    parameter int W     = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);

    logic [W-1:0] stg [SH_W+1];

    assign stg[0] = din;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int S = 1 << i;
        assign stg[i+1] = amt[i] ? {stg[i][S-1:0], stg[i][W-1:S]} : stg[i];
    end

    assign dout = stg[SH_W];

endmodule

// File: rtl/shft_mask_gen.sv
module shft_mask_gen #(
    parameter int W     = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [SH_W-1:0] n,
    output logic [W-1:0]    keep_right,  // bits kept after a right shift by n
    output logic [W-1:0]    keep_left    // bits kept after a left shift by n
);

    logic [31:0] n_ext;
    assign n_ext = 32'(n);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign keep_right[i] = (n_ext + 32'(i)) < 32'(W);
        assign keep_left[i]  = 32'(i) >= n_ext;
    end

endmodule

// File: rtl/shft_op_select.sv
module shft_op_select
    import shft_pkg::*;
#(
    parameter int W     = 32,
    localparam int SH_W = $clog2(W)
) (
    input  shft_kind_e      kind,
    input  amt_class_t      cls,
    input  logic [SH_W-1:0] low,
    input  logic [W-1:0]    data,
    input  logic [W-1:0]    rot,
    input  logic [W-1:0]    keep_right,
    input  logic [W-1:0]    keep_left,
    input  logic            cin,
    output logic [W-1:0]    result,
    output logic            cout
);

    logic            sign;
    logic [SH_W-1:0] idx_right;
    logic [SH_W-1:0] idx_left;

    assign sign      = data[W-1];
    assign idx_right = low - SH_W'(1);
    assign idx_left  = SH_W'(0) - low;

    always_comb begin
        result = data;
        cout   = cin;
        if (cls.zero && zero_passes(kind)) begin
            result = data;
            cout   = cin;
        end else begin
            unique case (kind)
                SK_LSL: begin
                    if (cls.below) begin
                        result = rot & keep_left;
                        cout   = data[idx_left];
                    end else if (cls.exact) begin
                        result = '0;
                        cout   = data[0];
                    end else begin
                        result = '0;
                        cout   = 1'b0;
                    end
                end
                SK_LSR: begin
                    if (cls.below) begin
                        result = rot & keep_right;
                        cout   = data[idx_right];
                    end else if (cls.exact) begin
                        result = '0;
                        cout   = data[W-1];
                    end else begin
                        result = '0;
                        cout   = 1'b0;
                    end
                end
                SK_ASR: begin
                    if (cls.below) begin
                        result = (rot & keep_right) | (~keep_right & {W{sign}});
                        cout   = data[idx_right];
                    end else begin
                        result = {W{sign}};
                        cout   = sign;
                    end
                end
                SK_ROR: begin
                    result = rot;
                    cout   = rot[W-1];
                end
                SK_RRX: begin
                    result = {cin, data[W-1:1]};
                    cout   = data[0];
                end
                default: begin
                    result = data;
                    cout   = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/shft_barrel_top.sv
module shft_barrel_top
    import shft_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int AIN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     in_data,
    input  logic [2:0]       in_kind,
    input  logic [AIN_W-1:0] in_amount,
    input  logic             in_carry,
    output logic [W-1:0]     out_result,
    output logic             out_carry
);

    localparam int SH_W = $clog2(W);

    shft_kind_e      kind;
    amt_class_t      cls;
    logic [SH_W-1:0] low;
    logic [SH_W-1:0] rot_amt;
    logic [W-1:0]    rot;
    logic [W-1:0]    keep_right;
    logic [W-1:0]    keep_left;
    logic [W-1:0]    nxt_result;
    logic            nxt_carry;
    logic            amt_hi_unused;

    assign kind          = shft_kind_e'(in_kind);
    assign amt_hi_unused = ^in_amount[AIN_W-1:AMT_W];

    shft_amt_decode #(.W(W), .AMT_W(AMT_W)) dec_i (
        .amt (in_amount[AMT_W-1:0]),
        .cls (cls),
        .low (low)
    );

    assign rot_amt = rotates_left(kind) ? (SH_W'(0) - low) : low;

    shft_rot_right #(.W(W)) rot_i (
        .din  (in_data),
        .amt  (rot_amt),
        .dout (rot)
    );

    shft_mask_gen #(.W(W)) mask_i (
        .n          (low),
        .keep_right (keep_right),
        .keep_left  (keep_left)
    );

    shft_op_select #(.W(W)) sel_i (
        .kind       (kind),
        .cls        (cls),
        .low        (low),
        .data       (in_data),
        .rot        (rot),
        .keep_right (keep_right),
        .keep_left  (keep_left),
        .cin        (in_carry),
        .result     (nxt_result),
        .cout       (nxt_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_carry  <= 1'b0;
        end else begin
            out_result <= nxt_result;
            out_carry  <= nxt_carry;
        end
    end

endmodule

// File: rtl/shft_barrel_chk.sv
module shft_barrel_chk #(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int AIN_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     in_data,
    input logic [2:0]       in_kind,
    input logic [AIN_W-1:0] in_amount,
    input logic             in_carry,
    input logic [W-1:0]     out_result,
    input logic             out_carry
);

    logic [AMT_W-1:0] amt;
    logic             chk_hi_unused;

    assign amt           = in_amount[AMT_W-1:0];
    assign chk_hi_unused = ^in_amount[AIN_W-1:AMT_W];

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (out_result == '0) && !out_carry);

    assert_zero_amount_R3: assert property (@(posedge clk) disable iff (rst)
        (in_kind <= 3'd3 && amt == '0)
        |=> (out_result == $past(in_data)) && (out_carry == $past(in_carry)));

    assert_lsl_full_R4: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 3'd0 && amt == AMT_W'(W))
        |=> (out_result == '0) && (out_carry == $past(in_data[0])));

    assert_lsr_full_R5: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 3'd1 && amt == AMT_W'(W))
        |=> (out_result == '0) && (out_carry == $past(in_data[W-1])));

    assert_asr_saturate_R6: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 3'd2 && amt >= AMT_W'(W))
        |=> (out_result == {W{$past(in_data[W-1])}}) && (out_carry == $past(in_data[W-1])));

    assert_logical_beyond_R7: assert property (@(posedge clk) disable iff (rst)
        (in_kind <= 3'd1 && amt > AMT_W'(W))
        |=> (out_result == '0) && !out_carry);

    assert_ror_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 3'd3 && amt != '0)
        |=> (out_carry == out_result[W-1]));

    assert_rrx_R9: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 3'd4)
        |=> (out_carry == $past(in_data[0])) && (out_result[W-1] == $past(in_carry)));

    assert_spare_kind_R10: assert property (@(posedge clk) disable iff (rst)
        (in_kind >= 3'd5)
        |=> (out_result == $past(in_data)) && (out_carry == $past(in_carry)));

endmodule

bind shft_barrel_top shft_barrel_chk #(.W(W), .AMT_W(AMT_W), .AIN_W(AIN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_kind    (in_kind),
    .in_amount  (in_amount),
    .in_carry   (in_carry),
    .out_result (out_result),
    .out_carry  (out_carry)
);

// File: tb/shft_barrel_top_tb_top.sv
`timescale 1ns/1ps
module shft_barrel_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] in_data;
    logic [2:0]  in_kind;
    logic [31:0] in_amount;
    logic        in_carry;
    logic [31:0] out_result;
    logic        out_carry;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    shft_barrel_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_kind    (in_kind),
        .in_amount  (in_amount),
        .in_carry   (in_carry),
        .out_result (out_result),
        .out_carry  (out_carry)
    );

    // Behavioural reference built from the requirements, using wide shifts
    task automatic ref_shift(input logic [31:0] d, input int k, input logic [31:0] a,
                             input logic c, output logic [31:0] r, output logic co);
        int n;
        logic [63:0] t;
        logic signed [63:0] ts;
        n = int'(a & 32'hFF);
        r = d;
        co = c;
        case (k)
            0: if (n == 0) begin r = d; co = c; end
               else if (n <= 32) begin t = {32'b0, d} << n; r = t[31:0]; co = t[32]; end
               else begin r = 0; co = 0; end
            1: if (n == 0) begin r = d; co = c; end
               else if (n <= 32) begin t = {d, 32'b0} >> n; r = t[63:32]; co = t[31]; end
               else begin r = 0; co = 0; end
            2: if (n == 0) begin r = d; co = c; end
               else if (n < 32) begin ts = $signed({d, 32'b0}) >>> n; r = ts[63:32]; co = ts[31]; end
               else begin r = {32{d[31]}}; co = d[31]; end
            3: if (n == 0) begin r = d; co = c; end
               else begin
                   for (int i = 0; i < 32; i++) r[i] = d[(i + n) % 32];
                   co = r[31];
               end
            4: begin r = {c, d[31:1]}; co = d[0]; end
            default: begin r = d; co = c; end
        endcase
    endtask

    function automatic string tag_for(input int k, input int n);
        if (n == 0 && k <= 3) return "R3";
        case (k)
            0: return (n > 32) ? "R7" : "R4";
            1: return (n > 32) ? "R7" : "R5";
            2: return "R6";
            3: return "R8";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] gr, input logic gc,
                         input logic [31:0] er, input logic ec);
        checks++;
        if (gr !== er || gc !== ec) begin
            errors++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     req, gr, gc, er, ec);
        end
    endtask

    // Drive on a falling edge, let one rising edge pass, compare on the next falling edge
    task automatic apply(input string req, input logic [31:0] d, input int k,
                         input logic [31:0] a, input logic c);
        logic [31:0] er;
        logic ec;
        in_data = d; in_kind = 3'(k); in_amount = a; in_carry = c;
        ref_shift(d, k, a, c, er, ec);
        @(posedge clk);
        @(negedge clk);
        check(req, out_result, out_carry, er, ec);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: result=%h carry=%b expected completion", out_result, out_carry);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        logic [31:0] er;
        logic ec;
        rst = 1'b1;
        in_data = 32'hDEAD_BEEF; in_kind = 3'd4; in_amount = 32'd0; in_carry = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", out_result, out_carry, 32'h0, 1'b0);
        rst = 1'b0;

        // Sweep kinds and corner amounts with random data and both carry values
        for (int k = 0; k < 5; k++)
            for (int ai = 0; ai < 6; ai++)
                for (int rep = 0; rep < 4; rep++)
                    apply(tag_for(k, amts[ai]), $urandom, k, 32'(amts[ai]), rep[0]);

        // Directed vectors
        apply("R4", 32'h8000_0001, 0, 32'd1, 1'b0);   // 0x00000002, carry 1
        apply("R4", 32'h0000_0001, 0, 32'd32, 1'b0);  // 0, carry 1
        apply("R5", 32'h8000_0000, 1, 32'd32, 1'b0);  // 0, carry 1
        apply("R6", 32'hF000_0000, 2, 32'd4, 1'b1);   // 0xFF000000, carry 0
        apply("R6", 32'h8000_0000, 2, 32'd40, 1'b0);  // all ones, carry 1
        apply("R7", 32'hFFFF_FFFF, 0, 32'd33, 1'b1);  // 0, carry 0
        apply("R8", 32'h8000_0000, 3, 32'd64, 1'b0);  // unchanged, carry 1
        apply("R8", 32'h0000_0001, 3, 32'd1, 1'b0);   // 0x80000000, carry 1
        apply("R9", 32'h0000_0003, 4, 32'd17, 1'b1);  // 0x80000001, carry 1

        // R2: bits above bit 7 of the amount must not matter
        ref_shift(32'h0000_0100, 1, 32'd4, 1'b0, er, ec);
        in_data = 32'h0000_0100; in_kind = 3'd1; in_amount = 32'hABCD_0004; in_carry = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2", out_result, out_carry, er, ec);
        ref_shift(32'h1234_5678, 0, 32'd0, 1'b1, er, ec);
        in_data = 32'h1234_5678; in_kind = 3'd0; in_amount = 32'hFFFF_FF00; in_carry = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2", out_result, out_carry, er, ec);

        // R10: spare kind codes pass through
        for (int k = 5; k < 8; k++)
            apply("R10", $urandom, k, 32'd7, k[0]);

        // R11: back-to-back inputs, each visible exactly one edge later
        in_data = 32'h0000_00F0; in_kind = 3'd1; in_amount = 32'd4; in_carry = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11", out_result, out_carry, 32'h0000_000F, 1'b0);
        in_data = 32'h0000_00F0; in_kind = 3'd0; in_amount = 32'd28; in_carry = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11", out_result, out_carry, 32'h0000_0000, 1'b1);

        // R1 again: reset mid-run clears the outputs
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", out_result, out_carry, 32'h0, 1'b0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule